// File: doc/BRIEF.md
# Two-Port GPIO Expander Register Core

This block holds the register state and pin control for a 16-pin general-purpose I/O expander that is split into two 8-bit ports. A byte-wide register interface sits in front of it. A command byte sets a register pointer. After that, data bytes are written to the selected register or read from it. The pointer keeps its value until the next command byte.

There are eight byte registers, one of each kind per port. The input registers show the synchronized pin levels, with optional per-bit inversion. The output registers set the level driven on each pin. The inversion registers choose which input bits are inverted. The direction registers choose, for each pin, whether it is an input or a driven output. The block drives a per-pin output value and a per-pin output enable, and it samples the 16 pin levels through a two-flop synchronizer.

Top module: `gpio_bank_core`

## Requirements
- R1: After reset, both output registers read 0xFF, both inversion registers read 0x00 and both direction registers read 0xFF. `pin_out` is all ones and `pin_oe` is all zeros.
- R2: A pulse on `cmd_wr` loads the pointer from `cmd_data`. Each later `rd_en` pulse returns the selected register on `rd_data` one clock later. Each later `wr_en` pulse writes `wr_data` into the selected register. The pointer does not advance on an access. Register addresses are: 0 and 1 for input, 2 and 3 for output, 4 and 5 for inversion, 6 and 7 for direction. Even addresses are port 0 (pins 7:0) and odd addresses are port 1 (pins 15:8).
- R3: A read of address 0 or 1 returns the synchronized pin levels of that port. This holds whether the pin is an input or an output.
- R4: A write to address 0 or 1 changes no register and no pin output.
- R5: Each output register bit drives its pin on `pin_out`. A read of address 2 or 3 returns the stored bit, not the pin level.
- R6: An input-read bit equals the pin level XOR the inversion bit when the pin is an input. When the pin is an output, the inversion bit has no effect on the read.
- R7: For each pin, `pin_oe` is the inverse of its direction bit. A direction bit of 1 means input, with the driver off. A direction bit of 0 means output.
- R8: A command byte above 7 makes the pointer invalid. While the pointer is invalid, writes change nothing and reads return 0x00.
- R9: Reads of addresses 4 to 7 return the values last written to those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte (register pointer) |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Read result, valid the cycle after `rd_en` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Level to drive on each pin |
| pin_oe | output | 16 | Output enable for each pin |

## Verification
Input readback is tested with pin patterns that differ from the output register contents, for example pins at 0x00 while the output register holds 0xA5. A design that returns the flop value instead of the pin level fails this test, and so does the reverse mistake. Inversion is tested with patterns whose high and low nibbles differ. The test runs once with every pin as an input and again with half the pins as outputs, which shows whether the direction bit gates the inversion. Command bytes 0x08 and 0xFF are each followed by a write and a full register sweep, which shows whether the upper command bits are decoded or dropped. Port 1 gets its own patterns so that a swap between the two ports is caught.

// File: rtl/gpio_bank_core.sv
module gpio_bank_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_data,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe
);
  logic [15:0] sync1, sync2, out_q, pol_q, cfg_q;
  logic [2:0]  ptr_q;
  logic        ptr_ok;
  logic [7:0]  sel_byte;

  wire [15:0] in_view = sync2 ^ (pol_q & cfg_q);

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr_q  <= 3'd0;
      ptr_ok <= 1'b1;
      out_q  <= 16'hFFFF;
      pol_q  <= 16'h0000;
      cfg_q  <= 16'hFFFF;
    end else begin
      if (cmd_wr) begin
        ptr_q  <= cmd_data[2:0];
        ptr_ok <= (cmd_data[7:3] == 5'd0);
      end
      if (wr_en && ptr_ok)
        case (ptr_q)
          3'd2: out_q[7:0]  <= wr_data;
          3'd3: out_q[15:8] <= wr_data;
          3'd4: pol_q[7:0]  <= wr_data;
          3'd5: pol_q[15:8] <= wr_data;
          3'd6: cfg_q[7:0]  <= wr_data;
          3'd7: cfg_q[15:8] <= wr_data;
          default: ;
        endcase
    end

  always_comb
    case (ptr_q)
      3'd0:    sel_byte = in_view[7:0];
      3'd1:    sel_byte = in_view[15:8];
      3'd2:    sel_byte = out_q[7:0];
      3'd3:    sel_byte = out_q[15:8];
      3'd4:    sel_byte = pol_q[7:0];
      3'd5:    sel_byte = pol_q[15:8];
      3'd6:    sel_byte = cfg_q[7:0];
      default: sel_byte = cfg_q[15:8];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= ptr_ok ? sel_byte : 8'h00;

  assert_input_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr_ok && (ptr_q[2:1] == 2'b00) |=> $stable(out_q) && $stable(pol_q) && $stable(cfg_q));

  assert_invalid_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !ptr_ok |=> $stable(out_q) && $stable(pol_q) && $stable(cfg_q));

  assert_invalid_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ptr_ok |=> rd_data == 8'h00);

  assert_out_readback_flop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && ptr_ok && (ptr_q == 3'd2) |=> rd_data == $past(out_q[7:0]));

  assert_dir_write_sets_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr_ok && (ptr_q == 3'd6) |=> pin_oe[7:0] == ~$past(wr_data));

  assert_out_write_drives_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr_ok && (ptr_q == 3'd3) |=> pin_out[15:8] == $past(wr_data));
endmodule

// File: tb/test_gpio_bank_core.sv
module test_gpio_bank_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  cmd_data = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [8];
  bit done = 1'b0;

  gpio_bank_core i_gpio_bank_core (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put_cmd(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = b;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic get_data(output logic [7:0] b);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; b = rd_data;
  endtask

  task automatic write_reg(input int a, input logic [7:0] b);
    put_cmd(8'(a)); put_data(b);
    if (a >= 2) mdl[a] = b;
  endtask

  task automatic read_check(input string req, input int a, input logic [7:0] exp);
    logic [7:0] v;
    put_cmd(8'(a)); get_data(v);
    check(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic sweep(input string req);
    for (int a = 2; a < 8; a++) read_check(req, a, mdl[a]);
    check(req, pin_out, {mdl[3], mdl[2]});
    check(req, pin_oe, ~{mdl[7], mdl[6]});
  endtask

  task automatic set_pins(input logic [15:0] p);
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    mdl[2] = 8'hFF; mdl[3] = 8'hFF; mdl[4] = 8'h00;
    mdl[5] = 8'h00; mdl[6] = 8'hFF; mdl[7] = 8'hFF;
    check("R1 pin_out", pin_out, 16'hFFFF);
    check("R1 pin_oe", pin_oe, 16'h0000);
    sweep("R1 defaults");
  endtask

  task automatic t_pointer_hold;
    logic [7:0] v;
    write_reg(4, 8'h5A);
    get_data(v); check("R2 repeat read", {8'h00, v}, 16'h005A);
    get_data(v); check("R2 pointer held", {8'h00, v}, 16'h005A);
    put_data(8'h3C); mdl[4] = 8'h3C;
    get_data(v); check("R2 write same pointer", {8'h00, v}, 16'h003C);
    write_reg(4, 8'h00);
  endtask

  task automatic t_input_read;
    set_pins(16'h96C3);
    read_check("R3 port0 inputs", 0, 8'hC3);
    read_check("R3 port1 inputs", 1, 8'h96);
    write_reg(2, 8'hA5);
    write_reg(6, 8'h00);
    set_pins(16'h9600);
    read_check("R3 port0 as outputs shows pin", 0, 8'h00);
    read_check("R5 output reads flop", 2, 8'hA5);
    check("R5 pin_out", pin_out[7:0], 8'hA5);
    check("R7 oe on", pin_oe[7:0], 8'hFF);
    write_reg(6, 8'hFF);
    check("R7 oe off", pin_oe[7:0], 8'h00);
  endtask

  task automatic t_input_write_ignored;
    write_reg(0, 8'h12);
    write_reg(1, 8'h34);
    sweep("R4 input write ignored");
    read_check("R4 input unchanged", 1, 8'h96);
  endtask

  task automatic t_polarity;
    set_pins(16'h5533);
    write_reg(4, 8'h0F);
    read_check("R6 invert inputs", 0, 8'h3C);
    write_reg(6, 8'hF0);
    read_check("R6 inversion gated by direction", 0, 8'h33);
    check("R7 mixed oe", pin_oe[7:0], 8'h0F);
    write_reg(5, 8'hFF);
    read_check("R6 port1 invert", 1, 8'hAA);
    write_reg(7, 8'h0F);
    read_check("R6 port1 mixed", 1, 8'h55 ^ 8'h0F);
    check("R7 port1 oe", pin_oe[15:8], 8'hF0);
  endtask

  task automatic t_stored;
    write_reg(3, 8'h81);
    check("R5 port1 pin_out", pin_out[15:8], 8'h81);
    write_reg(5, 8'h24);
    write_reg(7, 8'hC3);
    sweep("R9 stored readback");
  endtask

  task automatic t_invalid;
    logic [7:0] v;
    put_cmd(8'h08); put_data(8'h00);
    get_data(v); check("R8 read invalid 0x08", {8'h00, v}, 16'h0000);
    put_cmd(8'hFF); put_data(8'h00);
    get_data(v); check("R8 read invalid 0xFF", {8'h00, v}, 16'h0000);
    put_cmd(8'h0E); put_data(8'h11);
    sweep("R8 invalid write ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pointer_hold;
    t_input_read;
    t_input_write_ignored;
    t_polarity;
    t_stored;
    t_invalid;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule